// File: doc/BRIEF.md
# Receive Burst Interrupt Coalescer

This block sits beside a network receive path and decides whether received frames can be moved as one continuous DMA burst instead of one interrupt per frame. The frame parser reports each finished frame with a single-cycle end-of-frame strobe and three quality flags: length legal, CRC valid and destination address accepted. It also gives the frame's byte count and the buffer address the frame was written to. A good frame seen while idle opens a burst. Every later good frame that arrives within the gap limit joins that burst.

The burst closes when a frame fails any quality flag, or when the time since the last end-of-frame reaches the gap limit. The gap limit is 52 microseconds, counted in system clocks and derived from the clock frequency parameter. When the burst closes, the block publishes three totals to host-readable registers: the buffer address of the first frame, the frame count and the byte count. It also sets a sticky burst-done status bit and pulses the receive-OK and receive-DMA interrupt lines together for one cycle. A run of good frames therefore costs a single interrupt event instead of one per frame. Outside a burst, the reported operating mode falls back to the host-configured base mode.

Top module: `rx_burst_coalescer`

## Requirements
- R1: A good frame (end-of-frame strobe with length, CRC and address flags all high) sampled while idle opens a burst. From the next cycle `mode_o` reads 3, and no interrupt pulses.
- R2: Good frames sampled during a burst, each within the gap limit of the previous one, add one to the running frame count and their byte count to the running byte total. They raise no interrupt.
- R3: A frame with any flag low, sampled during a burst, closes the burst. That frame is left out of the published totals.
- R4: With LIMIT = CLK_MHZ*52 clocks, a good frame sampled LIMIT-1 edges after the previous end-of-frame keeps the burst open. With no further frame, the burst closes at the edge LIMIT clocks after the last end-of-frame.
- R5: On closing, the read port returns the first frame's buffer address at offset 0x26, the frame count at offset 0x28 and the byte total at offset 0x2A, all zero-extended to 16 bits and all zero after reset.
- R6: Each burst close pulses `irq_rx_ok_o` and `irq_rx_dma_o` together, high for the one cycle after the closing edge.
- R7: A burst close sets bit 7 of the status word at offset 0x2C. The bit stays set until a read strobe to offset 0x2C, which returns the bit set and clears it at that edge.
- R8: Outside a burst, `mode_o` equals `cfg_base_mode_i` (0 memory, 1 I/O, 2 plain DMA).
- R9: A frame with any flag low, sampled while idle, is ignored: no interrupt, no mode change, and the published registers keep their values.
- R10: Four back-to-back good frames, a gap longer than the limit, then five back-to-back good frames, followed by another such gap, give exactly two interrupt events.
- R11: After reset the interrupt lines are low, `mode_o` equals the base mode, and every readable register is zero.
- R12: A good frame sampled at the very edge where the gap limit expires closes the old burst (published without it) and opens a new burst that starts with that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_base_mode_i | input | 2 | Mode used outside bursts: 0 memory, 1 I/O, 2 plain DMA |
| eof_i | input | 1 | Single-cycle end-of-frame strobe |
| len_ok_i | input | 1 | Frame length is legal |
| crc_ok_i | input | 1 | Frame CRC is valid |
| da_ok_i | input | 1 | Destination address passed the filter |
| frame_len_i | input | LEN_W | Byte count of the ending frame |
| buf_addr_i | input | ADDR_W | Buffer address of the ending frame |
| host_addr_i | input | 8 | Register offset for the read port |
| host_rd_i | input | 1 | Read strobe; clears the status bit when the offset is 0x2C |
| host_rdata_o | output | 16 | Combinational read data for `host_addr_i` |
| mode_o | output | 2 | Current mode: 3 while a burst is open, else the base mode |
| irq_rx_ok_o | output | 1 | Receive-OK interrupt pulse at burst close |
| irq_rx_dma_o | output | 1 | Receive-DMA interrupt pulse at burst close |

## Verification
Every result passes through exactly one register after the edge that samples its cause. The mode, the published totals, the status bit and the interrupt pulses are therefore all due in the cycle right after the sampling edge. The gap closure is due exactly LIMIT clocks after the last end-of-frame edge. The bench drives inputs and samples outputs on the falling edge, so a value read straight after a frame task returns is the one due after that frame's edge. Gap cases are counted in whole falling edges (LIMIT-1 to stay open, LIMIT to close), and interrupts across long waits are tallied by a falling-edge monitor, so a stray pulse between explicit samples is still caught.

// File: rtl/rxbc_pkg.sv
package rxbc_pkg;
  typedef enum logic {ST_IDLE, ST_BURST} state_t;

  localparam logic [7:0] OFS_SOF    = 8'h26;
  localparam logic [7:0] OFS_FRAMES = 8'h28;
  localparam logic [7:0] OFS_BYTES  = 8'h2A;
  localparam logic [7:0] OFS_STAT   = 8'h2C;
  localparam int         STAT_DONE_BIT = 7;
  localparam int         DATA_W = 16;
  localparam logic [1:0] MODE_STREAM = 2'b11;
endpackage

// File: rtl/rxbc_gap_timer.sv
module rxbc_gap_timer #(
  parameter int LIMIT = 13000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic restart_i,
  output logic expire_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign expire_o = run_i && (cnt_q == LAST);

  always_comb begin
    if (restart_i || !run_i || expire_o) cnt_d = '0;
    else                                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4
  gap_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/rxbc_accum.sv
module rxbc_accum #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 11,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              add_i,
  input  logic              pub_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [ADDR_W-1:0] pub_sof_o,
  output logic [CNT_W-1:0]  pub_frames_o,
  output logic [CNT_W-1:0]  pub_bytes_o
);
  logic [ADDR_W-1:0] run_sof_q, run_sof_d;
  logic [CNT_W-1:0]  run_frames_q, run_frames_d;
  logic [CNT_W-1:0]  run_bytes_q, run_bytes_d;
  logic              run_en;

  assign run_en = start_i || add_i;

  always_comb begin
    run_sof_d    = run_sof_q;
    run_frames_d = run_frames_q;
    run_bytes_d  = run_bytes_q;
    if (start_i) begin
      run_sof_d    = addr_i;
      run_frames_d = CNT_W'(1);
      run_bytes_d  = CNT_W'(len_i);
    end else if (add_i) begin
      run_frames_d = run_frames_q + 1'b1;
      run_bytes_d  = run_bytes_q + CNT_W'(len_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_sof_q    <= '0;
      run_frames_q <= '0;
      run_bytes_q  <= '0;
    end else if (run_en) begin
      run_sof_q    <= run_sof_d;
      run_frames_q <= run_frames_d;
      run_bytes_q  <= run_bytes_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pub_sof_o    <= '0;
      pub_frames_o <= '0;
      pub_bytes_o  <= '0;
    end else if (pub_i) begin
      pub_sof_o    <= run_sof_q;
      pub_frames_o <= run_frames_q;
      pub_bytes_o  <= run_bytes_q;
    end
  end

  // R2
  frame_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (add_i && !start_i) |=> run_frames_q == $past(run_frames_q) + 1'b1);
endmodule

// File: rtl/rxbc_status.sv
module rxbc_status
  import rxbc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_i,
  input  logic              rd_i,
  input  logic [7:0]        addr_i,
  input  logic [ADDR_W-1:0] sof_i,
  input  logic [CNT_W-1:0]  frames_i,
  input  logic [CNT_W-1:0]  bytes_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic done_q, done_d, clr;

  assign clr = rd_i && (addr_i == OFS_STAT);

  always_comb begin
    if (set_i)    done_d = 1'b1;
    else if (clr) done_d = 1'b0;
    else          done_d = done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_SOF:    rdata_o = DATA_W'(sof_i);
      OFS_FRAMES: rdata_o = DATA_W'(frames_i);
      OFS_BYTES:  rdata_o = DATA_W'(bytes_i);
      OFS_STAT:   rdata_o[STAT_DONE_BIT] = done_q;
      default:    rdata_o = '0;
    endcase
  end

  // R7
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> done_q);
  // R7
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set_i) |=> !done_q);
endmodule

// File: rtl/rx_burst_coalescer.sv
module rx_burst_coalescer
  import rxbc_pkg::*;
#(
  parameter int CLK_MHZ = 250,
  parameter int GAP_US  = 52,
  parameter int ADDR_W  = 16,
  parameter int LEN_W   = 11,
  parameter int CNT_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_base_mode_i,
  input  logic              eof_i,
  input  logic              len_ok_i,
  input  logic              crc_ok_i,
  input  logic              da_ok_i,
  input  logic [LEN_W-1:0]  frame_len_i,
  input  logic [ADDR_W-1:0] buf_addr_i,
  input  logic [7:0]        host_addr_i,
  input  logic              host_rd_i,
  output logic [15:0]       host_rdata_o,
  output logic [1:0]        mode_o,
  output logic              irq_rx_ok_o,
  output logic              irq_rx_dma_o
);
  localparam int LIMIT = CLK_MHZ * GAP_US;

  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  state_t state_q, state_d;
  logic   good, bad, expire;
  logic   start, add, close;
  logic   irq_ok_q, irq_dma_q;
  logic [ADDR_W-1:0] pub_sof;
  logic [CNT_W-1:0]  pub_frames, pub_bytes;

  assign good = eof_i && len_ok_i && crc_ok_i && da_ok_i;
  assign bad  = eof_i && !good;

  always_comb begin
    state_d = state_q;
    start   = 1'b0;
    add     = 1'b0;
    close   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (good) begin
          start   = 1'b1;
          state_d = ST_BURST;
        end
      end
      ST_BURST: begin
        if (expire) begin
          close = 1'b1;
          if (good) start = 1'b1;
          else      state_d = ST_IDLE;
        end else if (bad) begin
          close   = 1'b1;
          state_d = ST_IDLE;
        end else if (good) begin
          add = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      state_q   <= ST_IDLE;
      irq_ok_q  <= 1'b0;
      irq_dma_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      irq_ok_q  <= close;
      irq_dma_q <= close;
    end
  end

  rxbc_gap_timer #(.LIMIT(LIMIT)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .run_i     (state_q == ST_BURST),
    .restart_i (start || add),
    .expire_o  (expire)
  );

  rxbc_accum #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_accum (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .start_i      (start),
    .add_i        (add),
    .pub_i        (close),
    .addr_i       (buf_addr_i),
    .len_i        (frame_len_i),
    .pub_sof_o    (pub_sof),
    .pub_frames_o (pub_frames),
    .pub_bytes_o  (pub_bytes)
  );

  rxbc_status #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_status (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .set_i    (close),
    .rd_i     (host_rd_i),
    .addr_i   (host_addr_i),
    .sof_i    (pub_sof),
    .frames_i (pub_frames),
    .bytes_i  (pub_bytes),
    .rdata_o  (host_rdata_o)
  );

  assign mode_o       = (state_q == ST_BURST) ? MODE_STREAM : cfg_base_mode_i;
  assign irq_rx_ok_o  = irq_ok_q;
  assign irq_rx_dma_o = irq_dma_q;

  // R1
  open_burst_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (state_q == ST_IDLE && good) |=> (mode_o == MODE_STREAM && !irq_rx_dma_o));
  // R3
  bad_close_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (state_q == ST_BURST && bad) |=> (irq_rx_dma_o && state_q == ST_IDLE));
  // R9
  idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (state_q == ST_IDLE && bad) |=> (!irq_rx_dma_o && state_q == ST_IDLE));
  // R6
  irq_pair_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    irq_rx_ok_o == irq_rx_dma_o);
endmodule

// File: tb/sim_rx_burst_coalescer.sv
`timescale 1ns/1ps
module sim_rx_burst_coalescer;
  localparam int LIMIT = 250 * 52;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_mode = 2'd2;
  logic        eof = 1'b0, len_ok = 1'b0, crc_ok = 1'b0, da_ok = 1'b0;
  logic [10:0] flen = '0;
  logic [15:0] baddr = '0;
  logic [7:0]  haddr = '0;
  logic        hrd = 1'b0;
  logic [15:0] rdata;
  logic [1:0]  mode;
  logic        irq_ok, irq_dma;

  int total = 0;
  int bad_n = 0;
  int irq_events = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  rx_burst_coalescer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_base_mode_i(cfg_mode),
    .eof_i(eof), .len_ok_i(len_ok), .crc_ok_i(crc_ok), .da_ok_i(da_ok),
    .frame_len_i(flen), .buf_addr_i(baddr),
    .host_addr_i(haddr), .host_rd_i(hrd), .host_rdata_o(rdata),
    .mode_o(mode), .irq_rx_ok_o(irq_ok), .irq_rx_dma_o(irq_dma)
  );

  always @(negedge clk) if (irq_dma) irq_events++;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad_n++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input bit l, input bit c, input bit d,
                      input logic [10:0] n, input logic [15:0] a);
    eof = 1'b1; len_ok = l; crc_ok = c; da_ok = d; flen = n; baddr = a;
    @(negedge clk);
    eof = 1'b0; len_ok = 1'b0; crc_ok = 1'b0; da_ok = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] v);
    haddr = a; #1; v = rdata;
  endtask

  task automatic rd_clear(output logic [15:0] v);
    haddr = 8'h2C; hrd = 1'b1; #1; v = rdata;
    @(negedge clk); hrd = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    check("R11 mode", mode, 2);
    check("R11 irq", {irq_ok, irq_dma}, 0);
    rd(8'h26, v); check("R11 sof", v, 0);
    rd(8'h28, v); check("R11 frames", v, 0);
    rd(8'h2A, v); check("R11 bytes", v, 0);
    rd(8'h2C, v); check("R11 status", v, 0);
  endtask

  task automatic t_crc_close();
    logic [15:0] v;
    int e0 = irq_events;
    send(1, 1, 1, 64, 16'h0100);
    check("R1 mode stream", mode, 3);
    check("R1 no irq", irq_dma, 0);
    send(1, 1, 1, 100, 16'h0180);
    send(1, 1, 1, 1500, 16'h0200);
    check("R2 no irq during burst", irq_events - e0, 0);
    send(1, 0, 1, 77, 16'h0900);
    check("R6 both irqs", {irq_ok, irq_dma}, 2'b11);
    check("R8 base mode", mode, 2);
    rd(8'h26, v); check("R5 sof", v, 16'h0100);
    rd(8'h28, v); check("R3 frames exclude bad", v, 3);
    rd(8'h2A, v); check("R2 bytes", v, 1664);
    @(negedge clk);
    check("R6 single cycle", {irq_ok, irq_dma}, 0);
    rd_clear(v); check("R7 status set", v[7], 1);
    rd(8'h2C, v); check("R7 status cleared", v, 0);
  endtask

  task automatic t_len_da_close();
    logic [15:0] v;
    send(1, 1, 1, 10, 16'h0200);
    send(0, 1, 1, 5, 16'h0210);
    check("R3 len bad closes", irq_dma, 1);
    rd(8'h28, v); check("R3 len frames", v, 1);
    rd(8'h2A, v); check("R3 len bytes", v, 10);
    cfg_mode = 2'd1;
    send(1, 1, 1, 20, 16'h0220);
    send(1, 1, 1, 30, 16'h0230);
    send(1, 1, 0, 40, 16'h0240);
    check("R3 da bad closes", irq_dma, 1);
    check("R8 io mode", mode, 1);
    rd(8'h26, v); check("R5 sof da", v, 16'h0220);
    rd(8'h2A, v); check("R3 da bytes", v, 50);
  endtask

  task automatic t_idle_bad();
    logic [15:0] v;
    int e0;
    @(negedge clk);
    e0 = irq_events;
    send(1, 0, 1, 99, 16'h0777);
    check("R9 mode", mode, 1);
    @(negedge clk);
    check("R9 no irq", irq_events - e0, 0);
    rd(8'h28, v); check("R9 frames kept", v, 2);
    rd(8'h26, v); check("R9 sof kept", v, 16'h0220);
  endtask

  task automatic t_gap();
    logic [15:0] v;
    int e0 = irq_events;
    send(1, 1, 1, 100, 16'h0300);
    repeat (LIMIT - 2) @(negedge clk);
    send(1, 1, 1, 50, 16'h0310);
    check("R4 gap LIMIT-1 stays open", mode, 3);
    repeat (LIMIT - 1) @(negedge clk);
    check("R4 not yet closed", irq_dma, 0);
    check("R4 no early irq", irq_events - e0, 0);
    @(negedge clk);
    check("R4 closes at LIMIT", irq_dma, 1);
    rd(8'h28, v); check("R4 frames", v, 2);
    rd(8'h2A, v); check("R4 bytes", v, 150);
  endtask

  task automatic t_coincide();
    logic [15:0] v;
    send(1, 1, 1, 40, 16'h0400);
    repeat (LIMIT - 1) @(negedge clk);
    send(1, 1, 1, 60, 16'h0500);
    check("R12 irq", irq_dma, 1);
    check("R12 still burst", mode, 3);
    rd(8'h28, v); check("R12 old frames", v, 1);
    rd(8'h2A, v); check("R12 old bytes", v, 40);
    repeat (LIMIT) @(negedge clk);
    check("R12 new burst closes", irq_dma, 1);
    rd(8'h26, v); check("R12 new sof", v, 16'h0500);
    rd(8'h2A, v); check("R12 new bytes", v, 60);
  endtask

  task automatic t_pattern();
    logic [15:0] v;
    int e0;
    @(negedge clk);
    e0 = irq_events;
    for (int i = 0; i < 4; i++) send(1, 1, 1, 64, 16'h0600 + 16'(i));
    repeat (LIMIT + 2) @(negedge clk);
    for (int i = 0; i < 5; i++) send(1, 1, 1, 64, 16'h0700 + 16'(i));
    repeat (LIMIT + 2) @(negedge clk);
    check("R10 two events", irq_events - e0, 2);
    rd(8'h28, v); check("R10 last frames", v, 5);
    rd(8'h26, v); check("R10 last sof", v, 16'h0700);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_crc_close();
    t_len_da_close();
    t_idle_bad();
    t_gap();
    t_coincide();
    t_pattern();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad_n);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad_n++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad_n);
      $finish;
    end
  end
endmodule